// File: doc/BRIEF.md
# Per-Channel White Balance Lookup

This block corrects the colour temperature of a video stream by passing each red, green and blue sub-pixel through its own programmable 256-entry table of 8-bit values. Pixels arrive with data-enable and horizontal/vertical sync. The remapped pixel leaves one clock later, and the three timing signals are delayed by the same amount so that they stay aligned with the data.

A small write port loads the tables. It carries a channel select, an address, a data byte and a strobe. A two-bit mode input sets how sub-pixels are read and how results are formatted.
- In full-width mode, all eight input bits index the table.
- In the two coarse modes, only the upper six bits index the table, so only every fourth entry is reachable.
- One coarse mode clears the two low result bits. The other returns the full 8-bit entry, which allows fine colour adjustment on a 6-bit source.

A bypass input forwards the pixel unchanged with the same latency. After reset every table holds the identity mapping, so the block is transparent until it is loaded.

Top module: `wb_lut`

## Requirements
- R1: There are three independent tables of 256 x 8 bits, selected for writing by wr_chan (0 = red, 1 = green, 2 = blue). A write with wr_chan = 3 changes no table, and a write to one channel leaves the other two unchanged.
- R2: In mode 0 (8-bit in, 8-bit out), each output sub-pixel equals its channel's table entry addressed by the full 8-bit input sub-pixel.
- R3: In modes 1 and 2 (6-bit input), the input sub-pixel's upper six bits v = in[7:2] address entry 4*v. The bits in[1:0] are ignored.
- R4: In mode 1 (6-bit in, 6-bit out), the output is the addressed entry with bits [1:0] forced to zero.
- R5: In mode 2 (6-bit in, 8-bit out), the output is the full 8-bit addressed entry.
- R6: The pixel data, out_de, out_hs and out_vs all appear exactly one clock after their inputs are sampled.
- R7: After reset every table entry i holds the value i, and all outputs are zero.
- R8: A table write applies to pixels sampled from the next clock onward. A pixel sampled in the same clock as a write to its address gets the old entry.
- R9: When bypass is 1, each output sub-pixel equals the input sub-pixel one clock earlier, regardless of the tables and the mode.
- R10: Mode code 3 behaves like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0: 8in/8out, 1: 6in/6out, 2: 6in/8out, 3: as 0 |
| bypass | input | 1 | Forward pixel unchanged |
| in_r | input | 8 | Red input sub-pixel |
| in_g | input | 8 | Green input sub-pixel |
| in_b | input | 8 | Blue input sub-pixel |
| in_de | input | 1 | Input data enable |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync |
| wr_en | input | 1 | Table write strobe |
| wr_chan | input | 2 | Table select for write |
| wr_addr | input | 8 | Table write address |
| wr_data | input | 8 | Table write data |
| out_r | output | 8 | Red output sub-pixel |
| out_g | output | 8 | Green output sub-pixel |
| out_b | output | 8 | Blue output sub-pixel |
| out_de | output | 1 | Delayed data enable |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |

## Verification
Every result, whether remapped data, bypassed data or the timing signals, is due one clock after the input is sampled. A table write is visible to pixels sampled one clock after the write strobe. The bench drives inputs on the falling edge, lets one rising edge capture them, and samples outputs on the following falling edge, exactly one clock later. For the same-cycle write case, it checks the pixel sampled together with the write, and then a repeat of that pixel one clock later, so that both sides of the write boundary are covered.

// File: rtl/wb_lut_pkg.sv
package wb_lut_pkg;
  localparam int PIX_W   = 8;
  localparam int ADDR_W  = 8;
  localparam int N_CHAN  = 3;
  localparam int DROP_W  = PIX_W - 6;
  localparam int MODE_W  = 2;
  localparam int CHSEL_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_FULL   = 2'd0,
    MODE_C6_O6  = 2'd1,
    MODE_C6_O8  = 2'd2,
    MODE_RSVD   = 2'd3
  } wb_mode_e;

  function automatic logic [ADDR_W-1:0] lut_index(input logic [MODE_W-1:0] m,
                                                   input logic [PIX_W-1:0] px);
    case (m)
      MODE_C6_O6, MODE_C6_O8: lut_index = {px[PIX_W-1:DROP_W], {DROP_W{1'b0}}};
      default:                lut_index = px;
    endcase
  endfunction

  function automatic logic [PIX_W-1:0] lut_format(input logic [MODE_W-1:0] m,
                                                   input logic [PIX_W-1:0] e);
    if (m == MODE_C6_O6) lut_format = {e[PIX_W-1:DROP_W], {DROP_W{1'b0}}};
    else                 lut_format = e;
  endfunction
endpackage

// File: rtl/wb_lut_table.sv
module wb_lut_table
  import wb_lut_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PIX_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [PIX_W-1:0]  rd_data
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= PIX_W'(i);
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // registered read: sees the contents before any write in this cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/wb_pipe.sv
module wb_pipe #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/wb_lut.sv
module wb_lut
  import wb_lut_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MODE_W-1:0]   mode,
  input  logic                bypass,
  input  logic [PIX_W-1:0]    in_r,
  input  logic [PIX_W-1:0]    in_g,
  input  logic [PIX_W-1:0]    in_b,
  input  logic                in_de,
  input  logic                in_hs,
  input  logic                in_vs,
  input  logic                wr_en,
  input  logic [CHSEL_W-1:0]  wr_chan,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [PIX_W-1:0]    wr_data,
  output logic [PIX_W-1:0]    out_r,
  output logic [PIX_W-1:0]    out_g,
  output logic [PIX_W-1:0]    out_b,
  output logic                out_de,
  output logic                out_hs,
  output logic                out_vs
);
  localparam int SIDE_W = 3 + MODE_W + 1;
  localparam int PIPE_W = N_CHAN * PIX_W + SIDE_W;

  logic [PIX_W-1:0]  px_in  [N_CHAN];
  logic [ADDR_W-1:0] rd_addr[N_CHAN];
  logic [PIX_W-1:0]  lut_q  [N_CHAN];
  logic [PIX_W-1:0]  raw_q  [N_CHAN];
  logic [PIX_W-1:0]  px_out [N_CHAN];

  // named events for the checker
  logic [ADDR_W-1:0] addr_r, addr_g, addr_b;
  logic [MODE_W-1:0] mode_q;
  logic              bypass_q;

  assign px_in[0] = in_r;
  assign px_in[1] = in_g;
  assign px_in[2] = in_b;

  genvar c;
  generate
    for (c = 0; c < N_CHAN; c++) begin : g_chan
      assign rd_addr[c] = lut_index(mode, px_in[c]);
      wb_lut_table u_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && (wr_chan == CHSEL_W'(c))),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr[c]),
        .rd_data (lut_q[c])
      );
      assign px_out[c] = bypass_q ? raw_q[c] : lut_format(mode_q, lut_q[c]);
    end
  endgenerate

  assign addr_r = rd_addr[0];
  assign addr_g = rd_addr[1];
  assign addr_b = rd_addr[2];

  logic [PIPE_W-1:0] pipe_d, pipe_q;
  assign pipe_d = {in_r, in_g, in_b, in_de, in_hs, in_vs, mode, bypass};

  wb_pipe #(.W(PIPE_W)) u_side (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pipe_d),
    .q     (pipe_q)
  );

  assign {raw_q[0], raw_q[1], raw_q[2], out_de, out_hs, out_vs, mode_q, bypass_q} = pipe_q;

  assign out_r = px_out[0];
  assign out_g = px_out[1];
  assign out_b = px_out[2];
endmodule

// File: rtl/wb_lut_chk.sv
module wb_lut_chk
  import wb_lut_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [MODE_W-1:0]  mode,
  input logic               bypass,
  input logic [PIX_W-1:0]   in_r,
  input logic [PIX_W-1:0]   in_g,
  input logic [PIX_W-1:0]   in_b,
  input logic               in_de,
  input logic               in_hs,
  input logic               in_vs,
  input logic [PIX_W-1:0]   out_r,
  input logic [PIX_W-1:0]   out_g,
  input logic [PIX_W-1:0]   out_b,
  input logic               out_de,
  input logic               out_hs,
  input logic               out_vs,
  input logic [ADDR_W-1:0]  addr_r,
  input logic [ADDR_W-1:0]  addr_g,
  input logic [ADDR_W-1:0]  addr_b
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R6: timing signals one clock behind
  a_r6_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (out_de == $past(in_de) && out_hs == $past(in_hs) && out_vs == $past(in_vs)));

  // R9: bypass forwards the pixel one clock later
  a_r9_bypass_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(bypass)) |->
      (out_r == $past(in_r) && out_g == $past(in_g) && out_b == $past(in_b)));

  // R4: 6-bit output mode clears the two low bits
  a_r4_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mode) == 2'd1 && !$past(bypass)) |->
      (out_r[1:0] == 2'b00 && out_g[1:0] == 2'b00 && out_b[1:0] == 2'b00));

  // R3: coarse modes only reach multiples of four
  a_r3_coarse_index: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 || mode == 2'd2) |->
      (addr_r[1:0] == 2'b00 && addr_g[1:0] == 2'b00 && addr_b[1:0] == 2'b00));
endmodule

bind wb_lut wb_lut_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .bypass(bypass),
  .in_r(in_r), .in_g(in_g), .in_b(in_b),
  .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs),
  .out_r(out_r), .out_g(out_g), .out_b(out_b),
  .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs),
  .addr_r(addr_r), .addr_g(addr_g), .addr_b(addr_b)
);

// File: tb/wb_lut_bench.sv
`timescale 1ns/1ps
module wb_lut_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       bypass = 1'b0;
  logic [7:0] in_r = '0, in_g = '0, in_b = '0;
  logic       in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_chan = '0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic [7:0] out_r, out_g, out_b;
  logic       out_de, out_hs, out_vs;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  wb_lut u_wb_lut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .bypass(bypass),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs),
    .wr_en(wr_en), .wr_chan(wr_chan), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs)
  );

  // bench's own view of the tables
  logic [7:0] ref_t [3][256];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // expected output per requirement text
  function automatic int expect_px(input int ch, input int m, input int px);
    int a;
    if (m == 1 || m == 2) a = (px / 4) * 4; else a = px;
    if (m == 1) return (ref_t[ch][a] / 4) * 4;
    return ref_t[ch][a];
  endfunction

  // drive a pixel on the falling edge, sample one clock later
  task automatic pix(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                     input logic de, input logic hs, input logic vs);
    in_r = r; in_g = g; in_b = b; in_de = de; in_hs = hs; in_vs = vs;
    @(negedge clk);
  endtask

  task automatic tbl_write(input logic [1:0] ch, input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_chan = ch; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (ch != 2'd3) ref_t[ch][a] = d;
  endtask

  task automatic t_reset;
    chk("R7 reset out_r", out_r, 0);
    chk("R7 reset out_de", out_de, 0);
    mode = 2'd0;
    pix(8'h37, 8'hC4, 8'hFF, 1, 0, 0);
    chk("R7 identity r", out_r, 8'h37);
    chk("R7 identity g", out_g, 8'hC4);
    chk("R7 identity b", out_b, 8'hFF);
  endtask

  task automatic t_program_full;
    tbl_write(2'd0, 8'h20, 8'hA1);
    tbl_write(2'd1, 8'h20, 8'h0F);
    tbl_write(2'd2, 8'h20, 8'hFF);
    tbl_write(2'd3, 8'h21, 8'h99);
    tbl_write(2'd0, 8'h22, 8'h5A);
    mode = 2'd0;
    pix(8'h20, 8'h20, 8'h20, 1, 0, 0);
    chk("R2 full r", out_r, expect_px(0, 0, 8'h20));
    chk("R2 full g", out_g, expect_px(1, 0, 8'h20));
    chk("R2 full b", out_b, expect_px(2, 0, 8'h20));
    pix(8'h21, 8'h21, 8'h21, 1, 0, 0);
    chk("R1 chan3 write ignored r", out_r, 8'h21);
    chk("R1 chan3 write ignored b", out_b, 8'h21);
    pix(8'h22, 8'h22, 8'h22, 1, 0, 0);
    chk("R1 red write only r", out_r, 8'h5A);
    chk("R1 red write leaves g", out_g, 8'h22);
  endtask

  task automatic t_coarse;
    mode = 2'd1;
    pix(8'h23, 8'h21, 8'h22, 1, 0, 0);
    chk("R4 6/6 r", out_r, 8'hA0);
    chk("R4 6/6 g", out_g, 8'h0C);
    chk("R3 6/6 b low bits ignored", out_b, 8'hFC);
    mode = 2'd2;
    pix(8'h23, 8'h22, 8'h21, 1, 0, 0);
    chk("R5 6/8 r", out_r, expect_px(0, 2, 8'h23));
    chk("R5 6/8 g", out_g, 8'h0F);
    chk("R3 6/8 b", out_b, 8'hFF);
    pix(8'h37, 8'h37, 8'h37, 1, 0, 0);
    chk("R3 6/8 entry 0x34", out_r, 8'h34);
  endtask

  task automatic t_rsvd;
    mode = 2'd3;
    pix(8'h23, 8'h20, 8'h22, 1, 0, 0);
    chk("R10 mode3 r", out_r, 8'h23);
    chk("R10 mode3 g", out_g, 8'h0F);
    chk("R10 mode3 r2", out_r, expect_px(0, 0, 8'h23));
  endtask

  task automatic t_sync;
    mode = 2'd0;
    in_de = 1'b1; in_hs = 1'b0; in_vs = 1'b1;
    chk("R6 de not early", out_de, 1);
    @(negedge clk);
    chk("R6 vs delayed", out_vs, 1);
    chk("R6 hs low", out_hs, 0);
    in_de = 1'b0; in_hs = 1'b1; in_vs = 1'b0;
    #1;
    chk("R6 de held", out_de, 1);
    @(negedge clk);
    chk("R6 de fell", out_de, 0);
    chk("R6 hs rose", out_hs, 1);
    chk("R6 vs fell", out_vs, 0);
  endtask

  task automatic t_bypass;
    bypass = 1'b1; mode = 2'd1;
    pix(8'h20, 8'h23, 8'h22, 1, 0, 0);
    chk("R9 bypass r", out_r, 8'h20);
    chk("R9 bypass g", out_g, 8'h23);
    chk("R9 bypass b", out_b, 8'h22);
    bypass = 1'b0; mode = 2'd0;
    pix(8'h20, 8'h20, 8'h20, 1, 0, 0);
    chk("R9 bypass released", out_r, 8'hA1);
  endtask

  task automatic t_write_timing;
    mode = 2'd0;
    in_r = 8'h10; in_g = 8'h10; in_b = 8'h10;
    wr_en = 1'b1; wr_chan = 2'd0; wr_addr = 8'h10; wr_data = 8'h55;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 same cycle old value", out_r, 8'h10);
    @(negedge clk);
    chk("R8 next cycle new value", out_r, 8'h55);
    chk("R8 other channel untouched", out_g, 8'h10);
  endtask

  initial begin
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < 256; i++) ref_t[c][i] = 8'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program_full();
    t_coarse();
    t_rsvd();
    t_sync();
    t_bypass();
    t_write_timing();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule